// File: doc/BRIEF.md
# Monitor-Mode Debug Exception Controller

This block sits beside a simple processor model that handles debug in monitor mode, where a debug event becomes an ordinary abort exception instead of halting the core. On each clock it takes event strobes from the breakpoint logic, the debug-enable bit, a monitor-mode select, the current status word and two program counters. When an event is accepted it produces the abort entry state: the new status word, the saved copy of the old one, the link address, the vector address, a debug fault-status flag, a method-of-entry code and a trace-buffer disable.

Breakpoints tied to an instruction (instruction breakpoint, breakpoint instruction) enter through the prefetch-abort vector. Data breakpoints and the two asynchronous breaks (external break, trace buffer full) enter through the data-abort vector. While the status word shows abort mode, the asynchronous breaks are not taken. They are held as pending and are replayed as soon as the status word shows any other mode, whether it got there by a restore or by a direct write. The breakpoint compare logic, instruction decode and the register file are outside this block.

Top module: `mon_dbg_exc_ctrl`

## Requirements
- R1: No exception is taken and no output changes unless both `dbg_en` and `mon_mode` are 1 in the sampling cycle.
- R2: A data breakpoint, an external break or a trace-full break is taken as a data abort: `pc_out` = 0x10 and `exc_is_data` = 1.
- R3: An instruction breakpoint or a breakpoint instruction is taken as a prefetch abort: `pc_out` = 0x0C and `exc_is_data` = 0.
- R4: `ev_vtrap` has no effect on any output or on pending state.
- R5: On entry, `trace_dis` and `fault_dbg` become 1 and `spsr_out` takes the value of `psr_in` from the sampling cycle. `trace_dis` and `fault_dbg` then stay at 1 until reset.
- R6: On entry, `psr_out` equals `psr_in` with bits [4:0] = 5'b10111, bit 5 = 0, bit 6 unchanged, bit 7 = 1, and bits [31:8] unchanged.
- R7: On entry, `lr_out` is `pc_next` + 4 for a data abort and `pc_cur` + 4 for a prefetch abort.
- R8: `moe_code` is 1 for an instruction breakpoint, 2 for a data breakpoint, 3 for a breakpoint instruction, 4 for an external break and 6 for trace full, and 0 after reset. When events arrive together, the order of precedence is: instruction breakpoint, breakpoint instruction, data breakpoint, external break, trace full.
- R9: When `psr_in[4:0]` = 5'b10111 (abort mode), external and trace-full breaks are recorded as pending and no exception is taken for them.
- R10: In the first enabled cycle in which `psr_in` is out of abort mode and a break is pending, that break is taken as a data abort, with `lr_out` = `pc_next` + 4.
- R11: Every exception taken clears all pending breaks, including any break that arrives in that same cycle.
- R12: The update is registered. `exc_taken` is high for exactly the cycle that follows each accepted sampling edge. Synchronous reset `rst` clears the pending breaks, `trace_dis`, `fault_dbg`, `moe_code` and all word outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dbg_en | input | 1 | Debug enable bit |
| mon_mode | input | 1 | Monitor debug mode selected |
| ev_ibrk | input | 1 | Instruction breakpoint hit |
| ev_bkpt | input | 1 | Breakpoint instruction executed |
| ev_dbrk | input | 1 | Data breakpoint hit |
| ev_xbrk | input | 1 | External debug break |
| ev_tbuf | input | 1 | Trace buffer full break |
| ev_vtrap | input | 1 | Vector trap event (ignored) |
| psr_in | input | 32 | Current status word |
| pc_cur | input | 32 | Address of the faulting instruction |
| pc_next | input | 32 | Address of the next instruction |
| psr_out | output | 32 | Status word after entry |
| spsr_out | output | 32 | Saved status word |
| lr_out | output | 32 | Link register value |
| pc_out | output | 32 | Exception vector address |
| fault_dbg | output | 1 | Debug fault-status flag (bit 9) |
| moe_code | output | 3 | Method-of-entry code |
| trace_dis | output | 1 | Trace buffer disable |
| exc_taken | output | 1 | Exception entered this cycle |
| exc_is_data | output | 1 | Last entry was a data abort |

## Verification
Every result is due exactly one clock after the edge that samples its stimulus. This holds for the entry outputs, for the pending latch and for a replayed break. The bench drives inputs on the falling edge and updates its reference model on the rising edge from those inputs. It compares every output on the next falling edge, so each comparison sees the state after exactly one register stage. The directed checks for ignored events, pending and replay look at `exc_taken` and the vector on the same falling edge that follows the cycle being checked.

// File: rtl/mdx_pkg.sv
package mdx_pkg;
  localparam int XLEN = 32;
  localparam int MOE_W = 3;
  localparam logic [XLEN-1:0] VEC_PABT = 32'h0000_000C;
  localparam logic [XLEN-1:0] VEC_DABT = 32'h0000_0010;
  localparam logic [4:0] ABT_MODE = 5'b10111;
  localparam logic [XLEN-1:0] LINK_OFS = 32'd4;

  typedef enum logic [MOE_W-1:0] {
    MOE_RESET = 3'd0,
    MOE_IBRK  = 3'd1,
    MOE_DBRK  = 3'd2,
    MOE_BKPT  = 3'd3,
    MOE_XBRK  = 3'd4,
    MOE_TBUF  = 3'd6
  } moe_t;

  function automatic logic in_abort(input logic [XLEN-1:0] psr);
    return psr[4:0] == ABT_MODE;
  endfunction

  function automatic logic [XLEN-1:0] abort_psr(input logic [XLEN-1:0] psr);
    logic [XLEN-1:0] r;
    r = psr;
    r[4:0] = ABT_MODE;
    r[5] = 1'b0;
    r[7] = 1'b1;
    return r;
  endfunction

  function automatic logic [XLEN-1:0] link_addr(input logic is_data,
                                                input logic [XLEN-1:0] pc_cur,
                                                input logic [XLEN-1:0] pc_next);
    return (is_data ? pc_next : pc_cur) + LINK_OFS;
  endfunction
endpackage

// File: rtl/mdx_event_sort.sv
module mdx_event_sort
  import mdx_pkg::*;
(
  input  logic en,
  input  logic abort,
  input  logic ibrk,
  input  logic bkpt,
  input  logic dbrk,
  input  logic xbrk,
  input  logic tbuf,
  input  logic pend_x,
  input  logic pend_t,
  output logic take,
  output moe_t code,
  output logic is_data
);
  logic x_req, t_req;

  // asynchronous breaks are only eligible outside abort mode
  assign x_req = (xbrk | pend_x) & ~abort;
  assign t_req = (tbuf | pend_t) & ~abort;

  always_comb begin
    code = MOE_RESET;
    if (en) begin
      if (ibrk)       code = MOE_IBRK;
      else if (bkpt)  code = MOE_BKPT;
      else if (dbrk)  code = MOE_DBRK;
      else if (x_req) code = MOE_XBRK;
      else if (t_req) code = MOE_TBUF;
    end
  end

  assign take    = (code != MOE_RESET);
  assign is_data = take & (code != MOE_IBRK) & (code != MOE_BKPT);
endmodule

// File: rtl/mdx_pend_hold.sv
module mdx_pend_hold (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic abort,
  input  logic take,
  input  logic xbrk,
  input  logic tbuf,
  output logic pend_x,
  output logic pend_t
);
  always_ff @(posedge clk) begin
    if (rst || take) begin
      pend_x <= 1'b0;
      pend_t <= 1'b0;
    end else if (en && abort) begin
      pend_x <= pend_x | xbrk;
      pend_t <= pend_t | tbuf;
    end
  end
endmodule

// File: rtl/mdx_entry_regs.sv
module mdx_entry_regs
  import mdx_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            take,
  input  moe_t            code,
  input  logic            is_data,
  input  logic [XLEN-1:0] psr_in,
  input  logic [XLEN-1:0] pc_cur,
  input  logic [XLEN-1:0] pc_next,
  output logic [XLEN-1:0] psr_out,
  output logic [XLEN-1:0] spsr_out,
  output logic [XLEN-1:0] lr_out,
  output logic [XLEN-1:0] pc_out,
  output logic            fault_dbg,
  output logic [MOE_W-1:0] moe_code,
  output logic            trace_dis,
  output logic            exc_taken,
  output logic            exc_is_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      psr_out     <= '0;
      spsr_out    <= '0;
      lr_out      <= '0;
      pc_out      <= '0;
      fault_dbg   <= 1'b0;
      moe_code    <= MOE_RESET;
      trace_dis   <= 1'b0;
      exc_taken   <= 1'b0;
      exc_is_data <= 1'b0;
    end else begin
      exc_taken <= take;
      if (take) begin
        psr_out     <= abort_psr(psr_in);
        spsr_out    <= psr_in;
        lr_out      <= link_addr(is_data, pc_cur, pc_next);
        pc_out      <= is_data ? VEC_DABT : VEC_PABT;
        fault_dbg   <= 1'b1;
        moe_code    <= code;
        trace_dis   <= 1'b1;
        exc_is_data <= is_data;
      end
    end
  end
endmodule

// File: rtl/mon_dbg_exc_ctrl.sv
module mon_dbg_exc_ctrl
  import mdx_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             dbg_en,
  input  logic             mon_mode,
  input  logic             ev_ibrk,
  input  logic             ev_bkpt,
  input  logic             ev_dbrk,
  input  logic             ev_xbrk,
  input  logic             ev_tbuf,
  input  logic             ev_vtrap,
  input  logic [XLEN-1:0]  psr_in,
  input  logic [XLEN-1:0]  pc_cur,
  input  logic [XLEN-1:0]  pc_next,
  output logic [XLEN-1:0]  psr_out,
  output logic [XLEN-1:0]  spsr_out,
  output logic [XLEN-1:0]  lr_out,
  output logic [XLEN-1:0]  pc_out,
  output logic             fault_dbg,
  output logic [MOE_W-1:0] moe_code,
  output logic             trace_dis,
  output logic             exc_taken,
  output logic             exc_is_data
);
  logic dbg_active, abort_now, take, is_data, pend_x, pend_t, vtrap_seen;
  moe_t code;

  assign dbg_active = dbg_en & mon_mode;
  assign abort_now  = in_abort(psr_in);
  // vector traps are deliberately dropped in monitor mode
  assign vtrap_seen = ev_vtrap;

  mdx_event_sort u_sort (
    .en(dbg_active), .abort(abort_now),
    .ibrk(ev_ibrk), .bkpt(ev_bkpt), .dbrk(ev_dbrk),
    .xbrk(ev_xbrk), .tbuf(ev_tbuf),
    .pend_x(pend_x), .pend_t(pend_t),
    .take(take), .code(code), .is_data(is_data)
  );

  mdx_pend_hold u_pend (
    .clk(clk), .rst(rst), .en(dbg_active), .abort(abort_now), .take(take),
    .xbrk(ev_xbrk), .tbuf(ev_tbuf), .pend_x(pend_x), .pend_t(pend_t)
  );

  mdx_entry_regs u_regs (
    .clk(clk), .rst(rst), .take(take), .code(code), .is_data(is_data),
    .psr_in(psr_in), .pc_cur(pc_cur), .pc_next(pc_next),
    .psr_out(psr_out), .spsr_out(spsr_out), .lr_out(lr_out), .pc_out(pc_out),
    .fault_dbg(fault_dbg), .moe_code(moe_code), .trace_dis(trace_dis),
    .exc_taken(exc_taken), .exc_is_data(exc_is_data)
  );
endmodule

// File: rtl/mdx_checker.sv
module mdx_checker (
  input logic        clk,
  input logic        rst,
  input logic        dbg_en,
  input logic        mon_mode,
  input logic        ev_ibrk,
  input logic        ev_bkpt,
  input logic        ev_dbrk,
  input logic [31:0] psr_in,
  input logic [31:0] psr_out,
  input logic [31:0] pc_out,
  input logic        exc_taken,
  input logic        exc_is_data,
  input logic        trace_dis,
  input logic        fault_dbg,
  input logic        pend_x,
  input logic        pend_t
);
  assert_gate_R1: assert property (@(posedge clk) disable iff (rst)
    !(dbg_en && mon_mode) |=> !exc_taken);

  assert_dvec_R2: assert property (@(posedge clk) disable iff (rst)
    (exc_taken && exc_is_data) |-> pc_out == 32'h10);

  assert_pvec_R3: assert property (@(posedge clk) disable iff (rst)
    (exc_taken && !exc_is_data) |-> pc_out == 32'h0C);

  assert_flags_R5: assert property (@(posedge clk) disable iff (rst)
    exc_taken |-> (trace_dis && fault_dbg));

  assert_mode_R6: assert property (@(posedge clk) disable iff (rst)
    exc_taken |-> (psr_out[4:0] == 5'b10111 && !psr_out[5] && psr_out[7]));

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (dbg_en && mon_mode && psr_in[4:0] == 5'b10111 && !ev_ibrk && !ev_bkpt && !ev_dbrk)
      |=> !exc_taken);

  assert_clear_R11: assert property (@(posedge clk) disable iff (rst)
    exc_taken |-> (!pend_x && !pend_t));

  assert_reset_R12: assert property (@(posedge clk)
    rst |=> (!trace_dis && !exc_taken && !pend_x && !pend_t));
endmodule

bind mon_dbg_exc_ctrl mdx_checker u_chk (
  .clk(clk), .rst(rst), .dbg_en(dbg_en), .mon_mode(mon_mode),
  .ev_ibrk(ev_ibrk), .ev_bkpt(ev_bkpt), .ev_dbrk(ev_dbrk),
  .psr_in(psr_in), .psr_out(psr_out), .pc_out(pc_out),
  .exc_taken(exc_taken), .exc_is_data(exc_is_data),
  .trace_dis(trace_dis), .fault_dbg(fault_dbg),
  .pend_x(pend_x), .pend_t(pend_t)
);

// File: tb/mon_dbg_exc_ctrl_test.sv
`timescale 1ns/1ps
module mon_dbg_exc_ctrl_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dbg_en = 0, mon_mode = 0;
  logic ev_ibrk = 0, ev_bkpt = 0, ev_dbrk = 0, ev_xbrk = 0, ev_tbuf = 0, ev_vtrap = 0;
  logic [31:0] psr_in = 0, pc_cur = 0, pc_next = 0;
  logic [31:0] psr_out, spsr_out, lr_out, pc_out;
  logic fault_dbg, trace_dis, exc_taken, exc_is_data;
  logic [2:0] moe_code;

  int n_run = 0, n_fail = 0;
  bit started = 0;

  localparam logic [31:0] USR = 32'h2000_0050;
  localparam logic [31:0] ABT = 32'h6000_0017;

  always #5 clk = ~clk;

  mon_dbg_exc_ctrl uut (
    .clk(clk), .rst(rst), .dbg_en(dbg_en), .mon_mode(mon_mode),
    .ev_ibrk(ev_ibrk), .ev_bkpt(ev_bkpt), .ev_dbrk(ev_dbrk),
    .ev_xbrk(ev_xbrk), .ev_tbuf(ev_tbuf), .ev_vtrap(ev_vtrap),
    .psr_in(psr_in), .pc_cur(pc_cur), .pc_next(pc_next),
    .psr_out(psr_out), .spsr_out(spsr_out), .lr_out(lr_out), .pc_out(pc_out),
    .fault_dbg(fault_dbg), .moe_code(moe_code), .trace_dis(trace_dis),
    .exc_taken(exc_taken), .exc_is_data(exc_is_data)
  );

  // behavioural reference
  logic [31:0] m_psr, m_spsr, m_lr, m_pc;
  int m_moe;
  bit m_fault, m_trc, m_taken, m_data, m_px, m_pt;

  always @(posedge clk) begin
    bit en, abrt;
    int c;
    started = 1;
    m_taken = 0;
    if (rst) begin
      m_psr = 0; m_spsr = 0; m_lr = 0; m_pc = 0; m_moe = 0;
      m_fault = 0; m_trc = 0; m_data = 0; m_px = 0; m_pt = 0;
    end else begin
      en = dbg_en && mon_mode;
      abrt = (psr_in[4:0] == 5'h17);
      c = 0;
      if (en) begin
        if (ev_ibrk) c = 1;
        else if (ev_bkpt) c = 3;
        else if (ev_dbrk) c = 2;
        else if (!abrt && (ev_xbrk || m_px)) c = 4;
        else if (!abrt && (ev_tbuf || m_pt)) c = 6;
      end
      if (c != 0) begin
        m_taken = 1;
        m_data = (c != 1 && c != 3);
        m_moe = c;
        m_spsr = psr_in;
        m_psr = {psr_in[31:8], 1'b1, psr_in[6], 1'b0, 5'h17};
        m_lr = m_data ? pc_next + 4 : pc_cur + 4;
        m_pc = m_data ? 32'h10 : 32'h0C;
        m_fault = 1; m_trc = 1; m_px = 0; m_pt = 0;
      end else if (en && abrt) begin
        m_px = m_px | ev_xbrk;
        m_pt = m_pt | ev_tbuf;
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      chk("R12 exc_taken", {31'd0, exc_taken}, {31'd0, m_taken});
      chk("R2/R3 pc_out", pc_out, m_pc);
      chk("R2/R3 exc_is_data", {31'd0, exc_is_data}, {31'd0, m_data});
      chk("R6 psr_out", psr_out, m_psr);
      chk("R5 spsr_out", spsr_out, m_spsr);
      chk("R7 lr_out", lr_out, m_lr);
      chk("R8 moe_code", {29'd0, moe_code}, m_moe);
      chk("R5 fault_dbg", {31'd0, fault_dbg}, {31'd0, m_fault});
      chk("R5 trace_dis", {31'd0, trace_dis}, {31'd0, m_trc});
    end
  end

  // drive one cycle of stimulus: {ibrk,bkpt,dbrk,xbrk,tbuf,vtrap}
  task automatic step(logic [5:0] ev, logic [31:0] psr, logic [31:0] pcc);
    {ev_ibrk, ev_bkpt, ev_dbrk, ev_xbrk, ev_tbuf, ev_vtrap} = ev;
    psr_in = psr; pc_cur = pcc; pc_next = pcc + 32'h24;
    @(negedge clk);
    {ev_ibrk, ev_bkpt, ev_dbrk, ev_xbrk, ev_tbuf, ev_vtrap} = 6'd0;
  endtask

  initial begin
    #2_000_000;
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R12: reset state
    chk("R12 reset moe", {29'd0, moe_code}, 32'd0);
    chk("R12 reset trace_dis", {31'd0, trace_dis}, 32'd0);
    rst = 0;
    // R1: disabled paths
    step(6'b100000, USR, 32'h100);
    chk("R1 dbg_en=0 no entry", {31'd0, exc_taken}, 32'd0);
    dbg_en = 1;
    step(6'b001000, USR, 32'h104);
    chk("R1 mon_mode=0 no entry", {31'd0, exc_taken}, 32'd0);
    mon_mode = 1;
    // R4: vector trap ignored
    step(6'b000001, USR, 32'h108);
    chk("R4 vtrap no entry", {31'd0, exc_taken}, 32'd0);
    chk("R4 vtrap trace untouched", {31'd0, trace_dis}, 32'd0);
    // single events
    step(6'b100000, USR, 32'h200);
    chk("R3 ibrk vector", pc_out, 32'h0C);
    chk("R7 prefetch link", lr_out, 32'h204);
    step(6'b010000, 32'h8000_00F0, 32'h300);
    chk("R3 bkpt vector", pc_out, 32'h0C);
    step(6'b001000, 32'h0000_0053, 32'h400);
    chk("R2 dbrk vector", pc_out, 32'h10);
    chk("R7 data link", lr_out, 32'h428);
    step(6'b000100, USR, 32'h500);
    chk("R8 xbrk code", {29'd0, moe_code}, 32'd4);
    step(6'b000010, USR, 32'h600);
    chk("R8 tbuf code", {29'd0, moe_code}, 32'd6);
    // R8 priority combos
    step(6'b111111, USR, 32'h700);
    chk("R8 all -> ibrk", {29'd0, moe_code}, 32'd1);
    step(6'b011110, USR, 32'h710);
    chk("R8 bkpt over dbrk", {29'd0, moe_code}, 32'd3);
    step(6'b001110, USR, 32'h720);
    chk("R8 dbrk over async", {29'd0, moe_code}, 32'd2);
    step(6'b000110, USR, 32'h730);
    chk("R8 xbrk over tbuf", {29'd0, moe_code}, 32'd4);
    // R9/R10: pend in abort mode, replay on exit
    step(6'b000010, ABT, 32'h800);
    chk("R9 tbuf held in abort", {31'd0, exc_taken}, 32'd0);
    step(6'b000100, ABT, 32'h804);
    chk("R9 xbrk held in abort", {31'd0, exc_taken}, 32'd0);
    step(6'b000000, ABT, 32'h808);
    step(6'b000000, USR, 32'h900);
    chk("R10 replay taken", {31'd0, exc_taken}, 32'd1);
    chk("R10 replay code xbrk", {29'd0, moe_code}, 32'd4);
    chk("R10 replay link", lr_out, 32'h928);
    step(6'b000000, USR, 32'h904);
    chk("R11 tbuf cleared by replay", {31'd0, exc_taken}, 32'd0);
    // R11: sync event in abort clears pending
    step(6'b000110, ABT, 32'hA00);
    step(6'b100100, ABT, 32'hA04);
    chk("R11 ibrk in abort taken", {31'd0, exc_taken}, 32'd1);
    step(6'b000000, USR, 32'hA08);
    chk("R11 nothing replayed", {31'd0, exc_taken}, 32'd0);
    // disabled while pending keeps it held
    step(6'b000100, ABT, 32'hB00);
    dbg_en = 0;
    step(6'b000000, USR, 32'hB04);
    chk("R1 no replay while disabled", {31'd0, exc_taken}, 32'd0);
    dbg_en = 1;
    step(6'b000000, USR, 32'hB08);
    chk("R10 replay after re-enable", {31'd0, exc_taken}, 32'd1);
    // R12: reset clears pending and trace disable
    step(6'b000010, ABT, 32'hC00);
    rst = 1;
    step(6'b000000, ABT, 32'hC04);
    chk("R12 trace_dis cleared", {31'd0, trace_dis}, 32'd0);
    rst = 0;
    step(6'b000000, USR, 32'hC08);
    chk("R12 pending dropped", {31'd0, exc_taken}, 32'd0);
    step(6'b001000, 32'h1234_5640, 32'hD00);
    step(6'b000000, USR, 32'hD04);
    chk("R12 single-cycle pulse", {31'd0, exc_taken}, 32'd0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule